// File: doc/BRIEF.md
# Reloadable Table-Driven Constant Multiplier

This block multiplies an 8-bit unsigned operand by a constant. The constant has no register of its own. It is held as two small tables of precomputed multiples. The operand is split into a lower and an upper 4-bit half. Each half indexes its own 16-entry table, and each entry holds that index times the constant. The upper table's result is weighted by sixteen and added to the lower table's result, which gives a 16-bit product. There is no array of partial-product AND gates and no adder tree, only two lookups and one addition.

A host changes the constant by rewriting table entries through a synchronous write port. A two-bit target field picks the lower table, the upper table or both at once. Because both tables hold the same sixteen multiples, one pass of sixteen writes with both bits set loads a complete new constant. The product is registered and appears one cycle after the operand is presented.

Top module: `kmul_lut_top`

## Requirements
- R1: While `rst` is high at a rising edge, `prod_out` becomes 0 and every entry of both tables becomes 0, so the product stays 0 after reset until entries are written.
- R2: In the cycle after `mult_in` is presented, `prod_out` equals (lower[`mult_in[3:0]`] + 16 × upper[`mult_in[7:4]`]) modulo 2^16, where lower and upper are the table contents before that edge.
- R3: A rising edge with `wr_en` high and `wr_sel[0]` set stores `wr_data` into lower-table entry `wr_addr`.
- R4: A rising edge with `wr_en` high and `wr_sel[1]` set stores `wr_data` into upper-table entry `wr_addr`.
- R5: With `wr_sel` = 2'b11, one write stores the same `wr_data` at `wr_addr` in both tables.
- R6: A cycle with `wr_en` low, or with `wr_sel` = 2'b00, changes no table entry.
- R7: A lookup in the same cycle as a write to the addressed entry returns the entry's old value. The new value is seen from the next cycle on.
- R8: When both tables hold i × K for i = 0..15 (K ≤ 255), `prod_out` equals `mult_in` × K one cycle later for every operand.
- R9: The upper table's contribution starts at product bit 4, so `prod_out[3:0]` always equals bits 3:0 of the lower entry that was looked up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mult_in | input | 8 | Unsigned operand |
| wr_en | input | 1 | Table write enable |
| wr_sel | input | 2 | Write target: bit 0 lower table, bit 1 upper table |
| wr_addr | input | 4 | Entry index to write |
| wr_data | input | 12 | Entry value to write |
| prod_out | output | 16 | Registered product |

## Verification
The full sweep of all 256 operands is run against several table fillings. The first filling has only the lower table written, which shows that the lower half is indexed correctly and weighted by one. The second has only the upper table written, which shows the shift by four and confirms that the low product bits come from the lower table alone. The third is a true multiple set for two different constants, which confirms the complete multiply. Further patterns cover a write that collides with a lookup of the same entry, writes that are disabled or have no target, and entries at 4095 in both tables, which make the sum wrap past 16 bits.

// File: rtl/cm_pkg.sv
package cm_pkg;

    localparam int NIB_W   = 4;
    localparam int NUM_TBL = 2;
    localparam int IN_W    = NIB_W * NUM_TBL;
    localparam int ENTRY_W = 12;
    localparam int PROD_W  = ENTRY_W + NIB_W * (NUM_TBL - 1);
    localparam int DEPTH   = 1 << NIB_W;
    localparam int SEL_W   = NUM_TBL;

    typedef logic [NIB_W-1:0]   nib_t;
    typedef logic [ENTRY_W-1:0] entry_t;
    typedef logic [PROD_W-1:0]  prod_t;

    typedef enum logic [SEL_W-1:0] {
        WSEL_NONE = 2'b00,
        WSEL_LOW  = 2'b01,
        WSEL_HIGH = 2'b10,
        WSEL_BOTH = 2'b11
    } wsel_e;

    typedef struct packed {
        logic   en;
        wsel_e  sel;
        nib_t   addr;
        entry_t data;
    } wr_req_t;

    // Widen one table word and move it to the weight of its nibble.
    function automatic prod_t place_part(entry_t word, int unsigned idx);
        prod_t wide;
        wide = prod_t'(word);
        return wide << (idx * NIB_W);
    endfunction

endpackage

// File: rtl/cm_write_decode.sv
module cm_write_decode
    import cm_pkg::*;
(
    input  wr_req_t           req,
    output logic [NUM_TBL-1:0] tbl_we
);
    for (genvar t = 0; t < NUM_TBL; t++) begin : g_dec
        assign tbl_we[t] = req.en && req.sel[t];
    end
endmodule

// File: rtl/cm_nibble_table.sv
module cm_nibble_table
    import cm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   we,
    input  nib_t   waddr,
    input  entry_t wdata,
    input  nib_t   raddr,
    output entry_t rdata
);
    entry_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read sees the contents before any write at this edge.
    assign rdata = mem[raddr];
endmodule

// File: rtl/cm_part_sum.sv
module cm_part_sum
    import cm_pkg::*;
(
    input  prod_t parts [NUM_TBL],
    output prod_t total
);
    always_comb begin
        total = '0;
        for (int t = 0; t < NUM_TBL; t++) begin
            total = total + parts[t];
        end
    end
endmodule

// File: rtl/kmul_lut_top.sv
module kmul_lut_top
    import cm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [IN_W-1:0]    mult_in,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [NIB_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    output logic [PROD_W-1:0]  prod_out
);
    wr_req_t            req;
    logic [NUM_TBL-1:0] tbl_we;
    entry_t             rd_word [NUM_TBL];
    prod_t              parts   [NUM_TBL];
    prod_t              sum_next;
    prod_t              prod_q;

    assign req.en   = wr_en;
    assign req.sel  = wsel_e'(wr_sel);
    assign req.addr = wr_addr;
    assign req.data = wr_data;

    cm_write_decode u_dec (
        .req    (req),
        .tbl_we (tbl_we)
    );

    for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
        cm_nibble_table u_tbl (
            .clk   (clk),
            .rst   (rst),
            .we    (tbl_we[t]),
            .waddr (req.addr),
            .wdata (req.data),
            .raddr (mult_in[t*NIB_W +: NIB_W]),
            .rdata (rd_word[t])
        );
        assign parts[t] = place_part(rd_word[t], t);
    end

    cm_part_sum u_sum (
        .parts (parts),
        .total (sum_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
        end else begin
            prod_q <= sum_next;
        end
    end

    assign prod_out = prod_q;
endmodule

// File: rtl/kmul_lut_chk.sv
module kmul_lut_chk
    import cm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [IN_W-1:0]   mult_in,
    input logic              wr_en,
    input logic [PROD_W-1:0] prod_out,
    input entry_t            lo_rd,
    input entry_t            hi_rd
);
    // R1
    rst_clears_prod_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> prod_out == '0);

    // R2
    prod_matches_lookup_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> prod_out == (prod_t'($past(lo_rd)) + (prod_t'($past(hi_rd)) << NIB_W)));

    // R9
    low_bits_from_low_tbl_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> prod_out[NIB_W-1:0] == $past(lo_rd[NIB_W-1:0]));

    // R6
    idle_holds_prod_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !wr_en && !$past(wr_en) && $stable(mult_in)) |=> $stable(prod_out));
endmodule

bind kmul_lut_top kmul_lut_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mult_in  (mult_in),
    .wr_en    (wr_en),
    .prod_out (prod_out),
    .lo_rd    (rd_word[0]),
    .hi_rd    (rd_word[1])
);

// File: tb/tb_kmul_lut_top.sv
`timescale 1ns/1ps
module tb_kmul_lut_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mult_in = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [3:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic [15:0] prod_out;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R1";
    bit    chk_on = 1'b0;
    bit    done = 1'b0;

    int lo_m [16];
    int hi_m [16];
    int exp_v = 0;

    always #10 clk = ~clk;

    kmul_lut_top dut (
        .clk(clk), .rst(rst), .mult_in(mult_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data), .prod_out(prod_out)
    );

    task automatic check(input int act, input int expv, input string tag);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Behavioural reference: product from old contents, then apply writes.
    always @(posedge clk) begin
        if (rst) begin
            foreach (lo_m[i]) begin lo_m[i] = 0; hi_m[i] = 0; end
            exp_v = 0;
        end else begin
            exp_v = (lo_m[mult_in[3:0]] + hi_m[mult_in[7:4]] * 16) % 65536;
            if (wr_en && wr_sel[0]) lo_m[wr_addr] = int'(wr_data);
            if (wr_en && wr_sel[1]) hi_m[wr_addr] = int'(wr_data);
        end
        chk_on = 1'b1;
    end

    always @(negedge clk) begin
        if (chk_on && !done) check(int'(prod_out), exp_v, cur_tag);
    end

    task automatic step(input logic [7:0] v, input logic en, input logic [1:0] sel,
                        input logic [3:0] a, input logic [11:0] d);
        @(negedge clk);
        mult_in = v; wr_en = en; wr_sel = sel; wr_addr = a; wr_data = d;
    endtask

    task automatic sweep();
        for (int v = 0; v < 256; v++) step(8'(v), 1'b0, 2'b00, 4'd0, 12'd0);
    endtask

    task automatic load_const(input int k);
        for (int i = 0; i < 16; i++) step(8'd0, 1'b1, 2'b11, 4'(i), 12'(i * k));
    endtask

    task automatic sweep_const(input int k, input string tag);
        for (int v = 0; v < 256; v++) begin
            step(8'(v), 1'b0, 2'b00, 4'd0, 12'd0);
            @(posedge clk); #1;
            check(int'(prod_out), v * k, tag);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, then any operand reads empty tables
        cur_tag = "R1";
        step(8'hFF, 1'b0, 2'b00, 4'd0, 12'd0);
        rst = 1'b0;
        @(posedge clk); #1;
        check(int'(prod_out), 0, "R1");
        sweep();

        // R3: lower table only
        cur_tag = "R3";
        for (int i = 0; i < 16; i++) step(8'd0, 1'b1, 2'b01, 4'(i), 12'((i * 37 + 5) % 4096));
        sweep();

        // R4 and R9: upper table with distinct values, low bits stay from lower table
        cur_tag = "R4 R9";
        for (int i = 0; i < 16; i++) step(8'd0, 1'b1, 2'b10, 4'(i), 12'((i * 91) ^ 165));
        sweep();

        // R5 and R8: shared write of multiples of 173
        cur_tag = "R5";
        load_const(173);
        cur_tag = "R8";
        sweep_const(173, "R8 k173");

        // R7: collision of write and lookup on the same entries
        cur_tag = "R7";
        step(8'h55, 1'b1, 2'b11, 4'd5, 12'd1000);
        @(posedge clk); #1;
        check(int'(prod_out), 85 * 173, "R7 old entry");
        step(8'h55, 1'b0, 2'b00, 4'd0, 12'd0);
        @(posedge clk); #1;
        check(int'(prod_out), 1000 + 16000, "R7 new entry");
        step(8'h00, 1'b1, 2'b11, 4'd5, 12'(5 * 173));

        // R6: disabled writes and writes with no target
        cur_tag = "R6";
        for (int i = 0; i < 16; i++) step(8'(i * 17), 1'b0, 2'b11, 4'(i), 12'hABC);
        for (int i = 0; i < 16; i++) step(8'(i * 17), 1'b1, 2'b00, 4'(i), 12'h123);
        sweep_const(173, "R6");

        // R8: reload with a second constant
        cur_tag = "R8";
        load_const(255);
        sweep_const(255, "R8 k255");

        // R2: wrap of the sum past 16 bits
        cur_tag = "R2";
        step(8'd0, 1'b1, 2'b11, 4'd15, 12'hFFF);
        step(8'hFF, 1'b0, 2'b00, 4'd0, 12'd0);
        @(posedge clk); #1;
        check(int'(prod_out), 4079, "R2 wrap");
        step(8'hF0, 1'b0, 2'b00, 4'd0, 12'd0);
        @(posedge clk); #1;
        check(int'(prod_out), 65520, "R2 upper only");
        sweep();

        @(negedge clk);
        finish_run();
    end
endmodule